// File: doc/BRIEF.md
# Sound Memory Address Remapper

This block turns a logical sound-memory address, as issued by a line-oriented DMA engine, into a physical address inside a 16 MB backing store. The translation depends on a 3-bit capacity code held in a control register. Software changes that code only while no transfer is running. For each line access, the engine presents the logical address and the code. It gets back a 24-bit physical address and a hit flag. When the hit flag is low, the line lies beyond the configured capacity: a read of that line returns zeros and a write to it is dropped.

The mapping is not a plain modulo. For the three smaller capacities, every address bit at or above the 512-byte boundary moves up one place. For the largest capacity, one address bit is squeezed out. The result can come out through a register stage or be purely combinational, chosen by a parameter.

Top module: `sndmem_addr_map`

## Requirements
- R1: Before any other step, bits 31:26 and bits 4:0 of the logical address are discarded. Addresses that differ only in those bits give the same outputs, and a hit result always has phys bits 4:0 equal to zero.
- R2: Capacity code 0 selects 2 MB, 1 selects 4 MB, 2 selects 8 MB, 3 selects 16 MB and 4 selects 32 MB. Codes 5, 6 and 7 give exactly the results of code 4.
- R3: The hit flag is 1 exactly when the masked address (the address with the bits of R1 discarded) is below the selected capacity in bytes. Otherwise it is 0.
- R4: For codes 0 to 2, a hit result is phys = (masked / 512) * 1024 + (masked mod 512).
- R5: For code 3, a hit result is phys = masked.
- R6: For codes 4 to 7, a hit result is phys = (masked / 8 MB) * 4 MB + (masked mod 4 MB). Bit 22 of the masked address does not reach the output.
- R7: When the hit flag is 0, phys is all zeros.
- R8: With OUT_REG=1 (the default), both outputs reflect the inputs sampled at the previous rising clock edge, and both are zero while rst_ni is low. With OUT_REG=0, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low synchronous reset of the output register |
| log_addr_i | input | 32 | Logical byte address of the line |
| size_sel_i | input | 3 | Configured capacity code |
| phys_addr_o | output | 24 | Physical byte address in the 16 MB store |
| hit_o | output | 1 | 1 when the line lies inside the configured capacity |

## Verification
The hardest cases to reach are the edges of each capacity. The last in-range line, cap-32, must produce the highest folded address, and the first out-of-range line, cap, must force the output to zero. These sit far apart in the 32-bit space and differ between codes. The bench therefore computes cap for every code, including the aliased codes 5 to 7. It drives cap-32, cap-1, cap and cap+32 directly, then repeats them with junk in bits 31:26 and 4:0 so that the mirroring has to cancel out. A pseudo-random sweep below twice the capacity then covers the interior folding.

// File: rtl/sndmem_map_pkg.sv
`timescale 1ns/1ps
package sndmem_map_pkg;

  localparam int unsigned LINE_LG   = 5;   // 32-byte lines
  localparam int unsigned FOLD_LG   = 9;   // folding boundary at 512 bytes
  localparam int unsigned WINDOW_LG = 26;  // 64 MB mirror window
  localparam int unsigned STORE_LG  = 24;  // 16 MB physical store
  localparam int unsigned BASE_LG   = 21;  // capacity of code 0 is 2 MB
  localparam int unsigned TOP_CODE  = 4;   // codes above this alias to it

  typedef enum logic [1:0] {
    MAP_FOLD    = 2'd0,
    MAP_IDENT   = 2'd1,
    MAP_SQUEEZE = 2'd2
  } map_kind_e;

  function automatic logic [2:0] clamp_code(input logic [2:0] code);
    return (code > 3'(TOP_CODE)) ? 3'(TOP_CODE) : code;
  endfunction

  function automatic map_kind_e kind_of(input logic [2:0] code);
    logic [2:0] c;
    c = clamp_code(code);
    if (c < 3'd3)      return MAP_FOLD;
    else if (c == 3'd3) return MAP_IDENT;
    else               return MAP_SQUEEZE;
  endfunction

  // capacity in bytes, one bit wider than the window so 32 MB fits comfortably
  function automatic logic [WINDOW_LG:0] cap_of(input logic [2:0] code);
    return (WINDOW_LG+1)'(1) << (BASE_LG + 32'(clamp_code(code)));
  endfunction

  // insert a zero at bit FOLD_LG
  function automatic logic [STORE_LG-1:0] fold_addr(input logic [WINDOW_LG-1:0] m);
    logic [WINDOW_LG:0] t;
    t = {m[WINDOW_LG-1:FOLD_LG], 1'b0, m[FOLD_LG-1:0]};
    return t[STORE_LG-1:0];
  endfunction

  // drop bit STORE_LG-2 (bit 22)
  function automatic logic [STORE_LG-1:0] squeeze_addr(input logic [WINDOW_LG-1:0] m);
    logic [WINDOW_LG-2:0] t;
    t = {m[WINDOW_LG-1:STORE_LG-1], m[STORE_LG-3:0]};
    return t[STORE_LG-1:0];
  endfunction

endpackage

// File: rtl/sndmem_pre_mask.sv
`timescale 1ns/1ps
module sndmem_pre_mask #(
  parameter int unsigned LOG_W = 32,
  parameter int unsigned WIN_W = 26,
  parameter int unsigned LN_LG = 5
) (
  input  logic [LOG_W-1:0] addr_i,
  output logic [WIN_W-1:0] masked_o,
  output logic             alias_hi_o,
  output logic             line_off_o
);
  always_comb begin
    masked_o   = {addr_i[WIN_W-1:LN_LG], {LN_LG{1'b0}}};
    alias_hi_o = |addr_i[LOG_W-1:WIN_W];
    line_off_o = |addr_i[LN_LG-1:0];
  end
endmodule

// File: rtl/sndmem_range_chk.sv
`timescale 1ns/1ps
module sndmem_range_chk
  import sndmem_map_pkg::*;
#(
  parameter int unsigned WIN_W = 26,
  parameter int unsigned SEL_W = 3
) (
  input  logic [WIN_W-1:0] masked_i,
  input  logic [SEL_W-1:0] size_sel_i,
  output logic             over_o
);
  logic [WIN_W:0] cap_w;
  always_comb begin
    cap_w  = cap_of(size_sel_i);
    over_o = {1'b0, masked_i} >= cap_w;
  end
endmodule

// File: rtl/sndmem_remap.sv
`timescale 1ns/1ps
module sndmem_remap
  import sndmem_map_pkg::*;
#(
  parameter int unsigned WIN_W = 26,
  parameter int unsigned PHY_W = 24,
  parameter int unsigned SEL_W = 3
) (
  input  logic [WIN_W-1:0] masked_i,
  input  logic [SEL_W-1:0] size_sel_i,
  input  logic             over_i,
  output logic [PHY_W-1:0] phys_o,
  output logic             hit_o
);
  map_kind_e        kind_w;
  logic [PHY_W-1:0] fold_w, ident_w, squeeze_w, pick_w;

  always_comb begin
    kind_w    = kind_of(size_sel_i);
    fold_w    = fold_addr(masked_i);
    ident_w   = masked_i[PHY_W-1:0];
    squeeze_w = squeeze_addr(masked_i);
    unique case (kind_w)
      MAP_FOLD:    pick_w = fold_w;
      MAP_IDENT:   pick_w = ident_w;
      default:     pick_w = squeeze_w;
    endcase
    hit_o  = ~over_i;
    phys_o = over_i ? '0 : pick_w;
  end
endmodule

// File: rtl/sndmem_out_stage.sv
`timescale 1ns/1ps
module sndmem_out_stage #(
  parameter int unsigned W       = 25,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (OUT_REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) q_r <= '0;
        else         q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_comb
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/sndmem_addr_map.sv
`timescale 1ns/1ps
module sndmem_addr_map
  import sndmem_map_pkg::*;
#(
  parameter int unsigned LOG_W   = 32,
  parameter int unsigned SEL_W   = 3,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LOG_W-1:0]    log_addr_i,
  input  logic [SEL_W-1:0]    size_sel_i,
  output logic [STORE_LG-1:0] phys_addr_o,
  output logic                hit_o
);
  localparam int unsigned WIN_W = WINDOW_LG;
  localparam int unsigned PHY_W = STORE_LG;
  localparam int unsigned OUT_W = PHY_W + 1;

  logic [WIN_W-1:0] masked_w;
  logic             alias_hi_w, line_off_w, over_w, comb_hit_w;
  logic [PHY_W-1:0] comb_phys_w;
  logic [OUT_W-1:0] stage_q_w;

  sndmem_pre_mask #(.LOG_W(LOG_W), .WIN_W(WIN_W), .LN_LG(LINE_LG)) u_mask (
    .addr_i(log_addr_i), .masked_o(masked_w),
    .alias_hi_o(alias_hi_w), .line_off_o(line_off_w)
  );

  sndmem_range_chk #(.WIN_W(WIN_W), .SEL_W(SEL_W)) u_range (
    .masked_i(masked_w), .size_sel_i(size_sel_i), .over_o(over_w)
  );

  sndmem_remap #(.WIN_W(WIN_W), .PHY_W(PHY_W), .SEL_W(SEL_W)) u_remap (
    .masked_i(masked_w), .size_sel_i(size_sel_i), .over_i(over_w),
    .phys_o(comb_phys_w), .hit_o(comb_hit_w)
  );

  sndmem_out_stage #(.W(OUT_W), .OUT_REG(OUT_REG)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({comb_hit_w, comb_phys_w}), .q_o(stage_q_w)
  );

  assign hit_o       = stage_q_w[OUT_W-1];
  assign phys_addr_o = stage_q_w[PHY_W-1:0];
endmodule

// File: rtl/sndmem_addr_map_chk.sv
`timescale 1ns/1ps
module sndmem_addr_map_chk
  import sndmem_map_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           size_sel_i,
  input logic [WINDOW_LG-1:0] masked_w,
  input logic                 alias_hi_w,
  input logic                 line_off_w,
  input logic                 comb_hit_w,
  input logic [STORE_LG-1:0]  comb_phys_w,
  input logic                 hit_o,
  input logic [STORE_LG-1:0]  phys_addr_o
);
  logic past_ok_r;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) past_ok_r <= 1'b0;
    else         past_ok_r <= 1'b1;
  end

  // R1: the line-offset bits never reach a hit result
  a_r1_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_off_w && comb_hit_w) |-> (comb_phys_w[LINE_LG-1:0] == '0));

  // R3: a hit with high alias bits still lies inside capacity
  a_r3_alias_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alias_hi_w && comb_hit_w) |-> ({1'b0, masked_w} < cap_of(size_sel_i)));

  // R4: folded modes leave a hole at bit 9
  a_r4_fold_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_hit_w && clamp_code(size_sel_i) < 3'd3) |-> (comb_phys_w[FOLD_LG] == 1'b0));

  // R5: identity mode
  a_r5_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_hit_w && size_sel_i == 3'd3) |-> (comb_phys_w == masked_w[STORE_LG-1:0]));

  // R6: squeeze mode keeps the low 22 bits
  a_r6_low_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_hit_w && size_sel_i >= 3'd4) |-> (comb_phys_w[STORE_LG-3:0] == masked_w[STORE_LG-3:0]));

  // R7: a miss at the output carries a zero address
  a_r7_zero_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (phys_addr_o == '0));

  generate
    if (OUT_REG) begin : g_lat
      // R8: one-cycle latency
      a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok_r |-> (hit_o == $past(comb_hit_w) && phys_addr_o == $past(comb_phys_w)));
    end else begin : g_nolat
      // R8: combinational path
      a_r8_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok_r |-> (hit_o == comb_hit_w));
    end
  endgenerate
endmodule

bind sndmem_addr_map sndmem_addr_map_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .size_sel_i(size_sel_i),
  .masked_w(masked_w), .alias_hi_w(alias_hi_w), .line_off_w(line_off_w),
  .comb_hit_w(comb_hit_w), .comb_phys_w(comb_phys_w),
  .hit_o(hit_o), .phys_addr_o(phys_addr_o)
);

// File: tb/sndmem_addr_map_tb_top.sv
`timescale 1ns/1ps
module sndmem_addr_map_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] log_addr = '0;
  logic [2:0]  size_sel = '0;
  logic [23:0] phys_addr;
  logic        hit;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  sndmem_addr_map dut_i (
    .clk_i(clk), .rst_ni(rst_n), .log_addr_i(log_addr), .size_sel_i(size_sel),
    .phys_addr_o(phys_addr), .hit_o(hit)
  );

  function automatic longint cap_bytes(input int code);
    int e;
    e = (code > 4) ? 4 : code;
    return longint'(2 * 1024 * 1024) * (longint'(1) << e);
  endfunction

  function automatic longint masked_of(input logic [31:0] a);
    longint m;
    m = longint'(a) % (64 * 1024 * 1024);
    return m - (m % 32);
  endfunction

  function automatic bit exp_hit(input logic [31:0] a, input int code);
    return masked_of(a) < cap_bytes(code);
  endfunction

  function automatic longint exp_phys(input logic [31:0] a, input int code);
    longint m;
    m = masked_of(a);
    if (m >= cap_bytes(code)) return 0;
    if (code < 3)       return (m / 512) * 1024 + (m % 512);
    else if (code == 3) return m;
    else                return (m / (8 * 1024 * 1024)) * (4 * 1024 * 1024) + (m % (4 * 1024 * 1024));
  endfunction

  task automatic check(input logic [31:0] a, input int code, input string tag);
    bit     eh;
    longint ep;
    log_addr = a;
    size_sel = 3'(code);
    @(negedge clk);
    eh = exp_hit(a, code);
    ep = exp_phys(a, code);
    n_chk++;
    if (hit !== eh || longint'(phys_addr) !== ep) begin
      n_err++;
      $display("FAIL %s addr=%h code=%0d actual hit=%0b phys=%h expected hit=%0b phys=%h",
               tag, a, code, hit, phys_addr, eh, ep[23:0]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    longint      cap;
    repeat (3) @(negedge clk);
    log_addr = 32'h0012_3460; size_sel = 3'd3;
    @(negedge clk);
    n_chk++;
    if (hit !== 1'b0 || phys_addr !== '0) begin
      n_err++;
      $display("FAIL R8 reset actual hit=%0b phys=%h expected hit=0 phys=000000", hit, phys_addr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R8: new input not visible before the next rising edge
    log_addr = 32'h0000_0400; size_sel = 3'd0;
    #1;
    n_chk++;
    if (phys_addr !== 24'h12_3460 || hit !== 1'b1) begin
      n_err++;
      $display("FAIL R8 latency actual hit=%0b phys=%h expected hit=1 phys=123460", hit, phys_addr);
    end
    @(negedge clk);
    n_chk++;
    if (phys_addr !== 24'h00_0800 || hit !== 1'b1) begin
      n_err++;
      $display("FAIL R8 update actual hit=%0b phys=%h expected hit=1 phys=000800", hit, phys_addr);
    end

    for (int code = 0; code < 8; code++) begin
      cap = cap_bytes(code);
      check(32'h0, code, (code > 4) ? "R2" : "R3");
      check(32'(cap - 32), code, (code < 3) ? "R4" : (code == 3) ? "R5" : "R6");
      check(32'(cap - 1), code, "R1");
      check(32'(cap), code, "R7");
      check(32'(cap + 32), code, "R3");
      check(32'(cap - 32) + 32'h0400_0000, code, "R1");
      check(32'(cap - 32) + 32'hFC00_001F, code, "R1");
      check(32'(cap) + 32'h0C00_0000, code, "R7");
      check(32'hFFFF_FFFF, code, "R7");
      check(32'h0000_01FF, code, "R4");
      check(32'h0000_0200, code, "R4");
      check(32'h0040_0000, code, "R6");
      check(32'h00C0_0020, code, "R6");
      lfsr = 32'hACE1_0000 + 32'(code);
      for (int k = 0; k < 200; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        check(32'(longint'(lfsr) % (2 * cap)) | (lfsr & 32'hFC00_001F), code,
              (code < 3) ? "R4" : (code == 3) ? "R5" : "R6");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule